// File: doc/BRIEF.md
# Scatter-Gather Descriptor List Walker

This block sits in front of a hash engine's data fetcher. Software leaves a table of source descriptors in memory and gives the walker its base address with a start pulse. The walker reads the table one 8-byte entry at a time through a plain 32-bit read port. For each entry it hands one (segment address, segment length, last) tuple to the fetcher over a valid/ready stream.

Each entry holds two 32-bit words. The length word sits at entry offset 0 and the address word at offset 4. Entry n starts at base + 8*n. The read port returns each word already assembled in little-endian order, so the byte at the lowest address lands in bits 7:0, and the walker uses the word as it arrives.

The walk ends in one of two ways:
- The entry whose length word has bit 31 set is accepted downstream. The walker then gives a one-cycle done pulse.
- `MAX_ENTRIES` entries pass without that marker. The walker then gives a one-cycle error pulse.

In both cases the walker goes back to idle.

The read port takes one request at a time. A request is held with its address until `mem_req_ready_i` is seen. Responses come back on `mem_rsp_valid_i` after any number of cycles and are never back-pressured.

The tuple stream follows the usual back-pressure rule. Once `seg_valid_o` is high, the tuple stays unchanged until a cycle in which `seg_ready_i` is high. The walker reads no further table entry while a tuple is waiting.

Top module: `sg_list_walker`

## Requirements
- R1: After reset, `busy_o`, `mem_req_valid_o`, `seg_valid_o`, `done_o` and `err_o` are low. Whenever `busy_o` is low, no read request and no tuple is presented.
- R2: A `start_i` pulse while idle captures `base_addr_i` and begins a walk, and `busy_o` is high for the whole walk. A `start_i` pulse while busy is ignored: the walk in progress continues from its original base and produces the same tuples.
- R3: Entry n is read at base + 8*n. Its length word is requested first, at the entry address, and its address word second, at the entry address + 4. Only one request is in flight at a time. A request that is not yet accepted keeps its address.
- R4: `seg_len_o` equals bits 27:0 of the length word. Bits 30:28 of the length word have no effect on any output.
- R5: `seg_addr_o` equals bits 30:0 of the address word. Bit 31 of the address word has no effect.
- R6: `seg_last_o` equals bit 31 of the length word. After a tuple with this bit set is accepted, no further table read is issued.
- R7: A tuple is presented only after both of its words have returned, and never in a cycle with a read request pending. While `seg_ready_i` is low, `seg_valid_o` stays high and all tuple fields stay stable.
- R8: `done_o` is high for exactly one cycle, in the cycle after the tuple marked last is accepted. In that same cycle `busy_o` is already low.
- R9: If the tuple of entry `MAX_ENTRIES`-1 is accepted without the last marker, `err_o` pulses for one cycle in the next cycle, `done_o` stays low and the walker goes idle. A last marker on that same entry gives `done_o` and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a walk (used only when idle) |
| base_addr_i | input | ADDR_W | Byte address of entry 0 |
| busy_o | output | 1 | A walk is in progress |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_req_addr_o | output | ADDR_W | Byte address of the requested word |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data word (little-endian assembled) |
| seg_valid_o | output | 1 | Tuple valid |
| seg_ready_i | input | 1 | Fetcher accepts tuple |
| seg_addr_o | output | 31 | Segment byte address |
| seg_len_o | output | 28 | Segment length in bytes |
| seg_last_o | output | 1 | Tuple comes from the final entry |
| done_o | output | 1 | One-cycle pulse: walk ended on the last marker |
| err_o | output | 1 | One-cycle pulse: entry limit hit without marker |

## Verification
The hardest case to reach is the boundary of the entry limit. A list must run exactly `MAX_ENTRIES` entries, once with the marker on the final entry and once without it, so the bench builds the walker with a small limit and writes both tables. Stall cases are hard for the same reason. A start pulse landing mid-walk, and tuples held under downstream stalls, need both ports throttled together. The bench therefore runs the same lists with a slow toggling read-port ready, added response latency and a toggling tuple ready, and pulses start with a different base in the middle of a walk.

// File: rtl/sg_walk_pkg.sv
package sg_walk_pkg;

  localparam int unsigned WORD_W      = 32;
  localparam int unsigned SEG_LEN_W   = 28;
  localparam int unsigned SEG_ADDR_W  = 31;
  localparam int unsigned LAST_BIT    = 31;
  localparam int unsigned ENTRY_SHIFT = 3;   // 8-byte entries
  localparam int unsigned HI_WORD_OFS = 4;   // address word offset

  typedef struct packed {
    logic                  last;
    logic [SEG_LEN_W-1:0]  len;
    logic [SEG_ADDR_W-1:0] addr;
  } seg_t;

  typedef enum logic [2:0] {
    W_IDLE    = 3'd0,
    W_REQ_LEN = 3'd1,
    W_GET_LEN = 3'd2,
    W_REQ_ADR = 3'd3,
    W_GET_ADR = 3'd4,
    W_OFFER   = 3'd5
  } walk_state_t;

endpackage

// File: rtl/sg_entry_unpack.sv
module sg_entry_unpack
  import sg_walk_pkg::*;
(
  input  logic [WORD_W-1:0] len_word_i,
  input  logic [WORD_W-1:0] adr_word_i,
  output seg_t              seg_o
);
  // Words arrive assembled little-endian; fields are masked here.
  always_comb begin
    seg_o.last = len_word_i[LAST_BIT];
    seg_o.len  = len_word_i[SEG_LEN_W-1:0];
    seg_o.addr = adr_word_i[SEG_ADDR_W-1:0];
  end
endmodule

// File: rtl/sg_entry_ctr.sv
module sg_entry_ctr
  import sg_walk_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned MAX_ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              step_i,
  input  logic              hi_word_i,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic              at_limit_o
);
  localparam int unsigned IDX_W = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1;

  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] entry_ofs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      idx_q  <= '0;
    end else if (load_i) begin
      base_q <= base_i;
      idx_q  <= '0;
    end else if (step_i) begin
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign entry_ofs   = ADDR_W'(idx_q) << ENTRY_SHIFT;
  assign word_addr_o = base_q + entry_ofs + (hi_word_i ? ADDR_W'(HI_WORD_OFS) : '0);

  generate
    if (MAX_ENTRIES > 1) begin : g_multi
      assign at_limit_o = (idx_q == IDX_W'(MAX_ENTRIES - 1));
    end else begin : g_single
      assign at_limit_o = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/sg_list_walker.sv
module sg_list_walker
  import sg_walk_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned MAX_ENTRIES = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [ADDR_W-1:0]     base_addr_i,
  output logic                  busy_o,
  output logic                  mem_req_valid_o,
  input  logic                  mem_req_ready_i,
  output logic [ADDR_W-1:0]     mem_req_addr_o,
  input  logic                  mem_rsp_valid_i,
  input  logic [WORD_W-1:0]     mem_rsp_data_i,
  output logic                  seg_valid_o,
  input  logic                  seg_ready_i,
  output logic [SEG_ADDR_W-1:0] seg_addr_o,
  output logic [SEG_LEN_W-1:0]  seg_len_o,
  output logic                  seg_last_o,
  output logic                  done_o,
  output logic                  err_o
);
  walk_state_t       state_q;
  logic [WORD_W-1:0] len_word_q;
  logic [WORD_W-1:0] adr_word_q;
  logic              done_q;
  logic              err_q;
  seg_t              seg;
  logic              at_limit;
  logic              load;
  logic              step;
  logic              accept;

  assign load   = (state_q == W_IDLE) && start_i;
  assign accept = (state_q == W_OFFER) && seg_ready_i;
  assign step   = accept && !seg.last && !at_limit;

  sg_entry_ctr #(
    .ADDR_W      (ADDR_W),
    .MAX_ENTRIES (MAX_ENTRIES)
  ) i_ctr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load),
    .base_i      (base_addr_i),
    .step_i      (step),
    .hi_word_i   (state_q == W_REQ_ADR),
    .word_addr_o (mem_req_addr_o),
    .at_limit_o  (at_limit)
  );

  sg_entry_unpack i_unpack (
    .len_word_i (len_word_q),
    .adr_word_i (adr_word_q),
    .seg_o      (seg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= W_IDLE;
      len_word_q <= '0;
      adr_word_q <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        W_IDLE:    if (start_i) state_q <= W_REQ_LEN;
        W_REQ_LEN: if (mem_req_ready_i) state_q <= W_GET_LEN;
        W_GET_LEN: if (mem_rsp_valid_i) begin
                     len_word_q <= mem_rsp_data_i;
                     state_q    <= W_REQ_ADR;
                   end
        W_REQ_ADR: if (mem_req_ready_i) state_q <= W_GET_ADR;
        W_GET_ADR: if (mem_rsp_valid_i) begin
                     adr_word_q <= mem_rsp_data_i;
                     state_q    <= W_OFFER;
                   end
        W_OFFER:   if (seg_ready_i) begin
                     if (seg.last) begin
                       done_q  <= 1'b1;
                       state_q <= W_IDLE;
                     end else if (at_limit) begin
                       err_q   <= 1'b1;
                       state_q <= W_IDLE;
                     end else begin
                       state_q <= W_REQ_LEN;
                     end
                   end
        default:   state_q <= W_IDLE;
      endcase
    end
  end

  assign busy_o          = (state_q != W_IDLE);
  assign mem_req_valid_o = (state_q == W_REQ_LEN) || (state_q == W_REQ_ADR);
  assign seg_valid_o     = (state_q == W_OFFER);
  assign seg_addr_o      = seg.addr;
  assign seg_len_o       = seg.len;
  assign seg_last_o      = seg.last;
  assign done_o          = done_q;
  assign err_o           = err_q;
endmodule

// File: rtl/sg_list_walker_chk.sv
module sg_list_walker_chk
  import sg_walk_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  busy_o,
  input logic                  mem_req_valid_o,
  input logic                  mem_req_ready_i,
  input logic [ADDR_W-1:0]     mem_req_addr_o,
  input logic                  seg_valid_o,
  input logic                  seg_ready_i,
  input logic [SEG_ADDR_W-1:0] seg_addr_o,
  input logic [SEG_LEN_W-1:0]  seg_len_o,
  input logic                  seg_last_o,
  input logic                  done_o,
  input logic                  err_o
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!seg_valid_o && !mem_req_valid_o));

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  // R3
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o |-> (mem_req_addr_o[1:0] == 2'b00));

  // R7
  seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid_o && !seg_ready_i) |=>
      (seg_valid_o && $stable(seg_addr_o) && $stable(seg_len_o) && $stable(seg_last_o)));

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(seg_valid_o && mem_req_valid_o));

  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(seg_valid_o && seg_ready_i && seg_last_o) && !busy_o));

  // R9
  err_after_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ($past(seg_valid_o && seg_ready_i && !seg_last_o) && !busy_o && !done_o));
endmodule

bind sg_list_walker sg_list_walker_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .busy_o          (busy_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o),
  .seg_valid_o     (seg_valid_o),
  .seg_ready_i     (seg_ready_i),
  .seg_addr_o      (seg_addr_o),
  .seg_len_o       (seg_len_o),
  .seg_last_o      (seg_last_o),
  .done_o          (done_o),
  .err_o           (err_o)
);

// File: tb/test_sg_list_walker.sv
module test_sg_list_walker;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int MAX_E      = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] base = '0;
  logic busy, req_valid, req_ready, rsp_valid, seg_valid, seg_ready, seg_last, done, err;
  logic [ADDR_W-1:0] req_addr;
  logic [31:0] rsp_data;
  logic [30:0] seg_addr;
  logic [27:0] seg_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  sg_list_walker #(.ADDR_W(ADDR_W), .MAX_ENTRIES(MAX_E)) i_sg_list_walker (
    .clk(clk), .rst_n(rst_n), .start_i(start), .base_addr_i(base), .busy_o(busy),
    .mem_req_valid_o(req_valid), .mem_req_ready_i(req_ready), .mem_req_addr_o(req_addr),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_data_i(rsp_data),
    .seg_valid_o(seg_valid), .seg_ready_i(seg_ready), .seg_addr_o(seg_addr),
    .seg_len_o(seg_len), .seg_last_o(seg_last), .done_o(done), .err_o(err));

  int checks = 0;
  int errors = 0;

  // memory model and stall controls
  logic [31:0] mem [0:255];
  int   lat_cfg = 0;
  logic req_stall = 1'b0, seg_stall = 1'b0;
  logic tog_a = 1'b0, tog_b = 1'b0;
  logic pend = 1'b0;
  logic [7:0] pend_idx = '0;
  int   pend_cnt = 0;

  assign req_ready = req_stall ? tog_a : 1'b1;
  assign seg_ready = seg_stall ? tog_b : 1'b1;

  always @(posedge clk) begin
    tog_a <= ~tog_a;
    tog_b <= (tog_b == tog_a);
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_data <= '0; pend <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (pend) begin
        if (pend_cnt == 0) begin
          rsp_valid <= 1'b1; rsp_data <= mem[pend_idx]; pend <= 1'b0;
        end else pend_cnt <= pend_cnt - 1;
      end
      if (req_valid && req_ready) begin
        pend <= 1'b1; pend_idx <= req_addr[9:2]; pend_cnt <= lat_cfg;
      end
    end
  end

  // scoreboards
  logic [31:0] exp_req [$];
  logic [59:0] exp_seg [$];
  int done_seen = 0, err_seen = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (req_valid && req_ready) begin
        if (exp_req.size() == 0) check(1'b0, "R3 unexpected read", 64'(req_addr), 64'hx);
        else begin
          logic [31:0] e;
          e = exp_req.pop_front();
          check(req_addr == e, "R3 read address/order", 64'(req_addr), 64'(e));
        end
      end
      if (seg_valid && seg_ready) begin
        if (exp_seg.size() == 0) check(1'b0, "R6 unexpected tuple", 64'(seg_addr), 64'hx);
        else begin
          logic [59:0] e;
          e = exp_seg.pop_front();
          check({seg_last, seg_len, seg_addr} == e, "R4 R5 R6 tuple fields",
                64'({seg_last, seg_len, seg_addr}), 64'(e));
        end
      end
      if (done) begin
        done_seen++;
        check(!busy, "R8 busy low with done", 64'(busy), 64'd0);
      end
      if (err) err_seen++;
    end
  end

  // driver: builds a table, pushes expectations, runs the walk
  task automatic run_list(input logic [31:0] b, input int n_ent, input int last_at,
                          input int seed, input bit poke);
    int emit;
    emit = (last_at >= 0) ? last_at + 1 : MAX_E;
    for (int i = 0; i < n_ent; i++) begin
      logic [27:0] ln;
      logic [30:0] ad;
      logic [2:0]  junk;
      ln   = 28'h0000100 + 28'(seed * 28'h1357 + i * 28'h0A1);
      ad   = 31'h2000_0000 + 31'(seed * 31'h10_0010 + i * 31'h404);
      junk = 3'(seed + i) | 3'b001;
      mem[8'((b >> 2) + 2*i)]     = {(i == last_at), junk, ln};
      mem[8'((b >> 2) + 2*i + 1)] = {1'b1, ad};
      if (i < emit) begin
        exp_req.push_back(b + 32'(8*i));
        exp_req.push_back(b + 32'(8*i) + 32'd4);
        exp_seg.push_back({(i == last_at), ln, ad});
      end
    end
    done_seen = 0; err_seen = 0;
    @(negedge clk);
    base = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R2 busy after start", 64'(busy), 64'd1);
    if (poke) begin
      repeat (7) @(negedge clk);
      base = b + 32'h80; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int g = 0; g < 2000 && (done_seen + err_seen) == 0; g++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(done_seen == (last_at >= 0 ? 1 : 0), "R8 done pulse count", 64'(done_seen),
          64'(last_at >= 0 ? 1 : 0));
    check(err_seen == (last_at >= 0 ? 0 : 1), "R9 error pulse count", 64'(err_seen),
          64'(last_at >= 0 ? 0 : 1));
    check(exp_seg.size() == 0, "R6 all tuples seen", 64'(exp_seg.size()), 64'd0);
    check(exp_req.size() == 0 && !req_valid, "R6 no read past end", 64'(exp_req.size()), 64'd0);
    check(!busy && !seg_valid, "R1 idle after walk", 64'({busy, seg_valid}), 64'd0);
    exp_req.delete(); exp_seg.delete();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check({busy, req_valid, seg_valid, done, err} == 5'b0, "R1 reset state",
          64'({busy, req_valid, seg_valid, done, err}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !req_valid, "R1 idle without start", 64'({busy, req_valid}), 64'd0);

    // R6 single entry list
    run_list(32'h0000_0040, 1, 0, 1, 1'b0);
    // R4 R5 three entries with junk bits, nonzero base
    run_list(32'h0000_0108, 3, 2, 2, 1'b0);
    // R7 back-pressure on both ports, added latency
    lat_cfg = 2; req_stall = 1'b1; seg_stall = 1'b1;
    run_list(32'h0000_0200, 4, 3, 3, 1'b0);
    // R2 start while busy ignored
    run_list(32'h0000_0010, 4, 3, 4, 1'b1);
    lat_cfg = 0; req_stall = 1'b0; seg_stall = 1'b0;
    // R9 limit reached without marker
    run_list(32'h0000_0300, MAX_E + 1, -1, 5, 1'b0);
    // R9 marker exactly on the final allowed entry
    run_list(32'h0000_0280, MAX_E, MAX_E - 1, 6, 1'b0);
    // R9 limit with stalls
    seg_stall = 1'b1; lat_cfg = 1;
    run_list(32'h0000_0000, MAX_E, -1, 7, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule